// File: doc/BRIEF.md
# Issue-Tracking Operand Collector and Result Writer

This controller sits between an issue stage and a small arithmetic unit. It follows one operation at a time from issue to write-back. An issue strobe comes with an operation record: function code, invert and zero controls for the first operand, an immediate with its valid flag, and a two-bit read-skip mask. The controller captures that record in the issue cycle. From the next cycle it reports busy.

The controller fetches each needed source operand through its own release/go handshake. A release bit marks a port as waiting. The requester answers with a one-cycle go pulse that carries the operand value. The controller skips ports whose value is known without a read: a masked port, the second port when an immediate is used, and the first port when it is forced to zero.

When every needed operand has arrived, the arithmetic unit runs for a fixed number of cycles. The controller then raises write-release and holds it until a write-go arrives. The result appears on the data output only in that go cycle. Busy drops one cycle after the write is acknowledged, so no result is ever lost.

Top module: `cu_ctrl`

## Requirements
- R1: Busy rises in the cycle after an accepted issue. It stays high until the cycle after write-go is seen with write-release high, and it falls in that cycle.
- R2: Busy never rises unless issue was high in the preceding cycle. Busy is low in the cycle in which an accepted issue is presented.
- R3: The function code, operand controls, immediate and read-skip mask are captured in the issue cycle. Changing those inputs afterwards does not change the result or the set of ports read.
- R4: For each port that needs a read, its release bit (bit 0 for the first operand, bit 1 for the second) rises in the cycle after issue. The bit stays high for as long as go is withheld on that port.
- R5: A go pulse on a port whose release bit is high captures that port's slice of the source bus (bits 15:0 for port 0, bits 31:16 for port 1 at the default width). The release bit is low in the next cycle. Go may be raised in the first cycle in which release is high. Go on a port whose release bit is low has no effect.
- R6: A port is skipped, so its release bit never rises, when its read-skip mask bit is 1. Port 1 is also skipped when the immediate flag is 1, and port 0 is also skipped when the zero flag is 1. A skipped first operand reads as zero. A skipped second operand takes the immediate when the flag is set and zero otherwise.
- R7: The result uses A and B. A is the first operand, zeroed when skipped and then bit-inverted when the invert flag is set. B is the second operand. By function code: 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A XOR B, all modulo 2^16.
- R8: Write-release rises EXEC_CYCLES+1 cycles after the last operand is captured and holds until write-go. data_o carries the result in the write-go cycle and is zero in every other cycle.
- R9: An issue presented while busy is ignored. No release bit rises again within an operation once its port has been read.
- R10: With go answered within 7 cycles on every handshake, an operation finishes within 50 cycles of issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue strobe for a new operation |
| op_i | input | 2 | Function code |
| inv_a_i | input | 1 | Invert first operand |
| zero_a_i | input | 1 | Force first operand to zero, skip its read |
| imm_ok_i | input | 1 | Use the immediate as second operand, skip its read |
| imm_i | input | DATA_W | Immediate value |
| rd_mask_n_i | input | 2 | Per-port read skip, 1 = do not read |
| src_i | input | 2*DATA_W | Operand values, port p in slice p |
| rd_go_i | input | 2 | Per-port read acknowledge pulse |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | 2 | Per-port read request |
| wr_rel_o | output | 1 | Result ready for write |
| wr_go_i | input | 1 | Write acknowledge pulse |
| data_o | output | DATA_W | Result, valid in the write-go cycle |

## Verification
The assertions check on every cycle that busy only rises after an issue and only falls after a write acknowledge. They also check that a release bit, read or write, holds until its go and clears right after it. A release bit can rise only on the edge that accepts an issue, and a skipped port never raises one. The bench scenarios alone can show that the arithmetic results are correct and that data_o is quiet outside the go cycle. They also show that inputs scrambled after issue have no effect, that go pulses on idle ports and issues during busy are ignored, and that the whole operation fits the cycle budget under delayed handshakes.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } fn_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

endpackage

// File: rtl/cu_alu.sv
module cu_alu
    import cu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fn_e               fn_i,
    input  logic              inv_a_i,
    input  logic              zero_a_i,
    input  logic              imm_ok_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] res_o
);

    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] b_eff;

    always_comb begin
        a_eff = zero_a_i ? '0 : opa_i;
        if (inv_a_i) begin
            a_eff = ~a_eff;
        end
        b_eff = imm_ok_i ? imm_i : opb_i;
        unique case (fn_i)
            FN_ADD:  res_o = a_eff + b_eff;
            FN_SUB:  res_o = a_eff - b_eff;
            FN_AND:  res_o = a_eff & b_eff;
            default: res_o = a_eff ^ b_eff;
        endcase
    end

endmodule

// File: rtl/cu_rd_port.sv
module cu_rd_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              need_i,
    input  logic              go_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              rel_o,
    output logic [DATA_W-1:0] opnd_o
);

    typedef struct packed {
        logic              rel;
        logic [DATA_W-1:0] opnd;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.rel  = need_i;
            st_d.opnd = '0;
        end else if (st_q.rel && go_i) begin
            st_d.rel  = 1'b0;
            st_d.opnd = src_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel_o  = st_q.rel;
    assign opnd_o = st_q.opnd;

    AST_REL_HOLDS_UNTIL_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o && !go_i) |=> rel_o); // R4
    AST_REL_CLEARS_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_o && go_i) |=> !rel_o); // R5
    AST_SKIPPED_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !need_i) |=> !rel_o); // R6
    AST_REL_RISES_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_o) |-> $past(start_i)); // R9

endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl
    import cu_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int EXEC_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_i,
    input  logic [1:0]          op_i,
    input  logic                inv_a_i,
    input  logic                zero_a_i,
    input  logic                imm_ok_i,
    input  logic [DATA_W-1:0]   imm_i,
    input  logic [1:0]          rd_mask_n_i,
    input  logic [2*DATA_W-1:0] src_i,
    input  logic [1:0]          rd_go_i,
    output logic                busy_o,
    output logic [1:0]          rd_rel_o,
    output logic                wr_rel_o,
    input  logic                wr_go_i,
    output logic [DATA_W-1:0]   data_o
);

    localparam int NSRC  = 2;
    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EXEC_CYCLES - 1);

    typedef struct packed {
        phase_e            phase;
        fn_e               fn;
        logic              inv_a;
        logic              zero_a;
        logic              imm_ok;
        logic [DATA_W-1:0] imm;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] result;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic              accept;
    logic [NSRC-1:0]   need;
    logic [NSRC-1:0]   rel;
    logic [DATA_W-1:0] opnd [NSRC];
    logic [DATA_W-1:0] alu_res;

    assign accept  = issue_i && (st_q.phase == PH_IDLE);
    assign need[0] = !rd_mask_n_i[0] && !zero_a_i;
    assign need[1] = !rd_mask_n_i[1] && !imm_ok_i;

    for (genvar p = 0; p < NSRC; p++) begin : g_port
        cu_rd_port #(.DATA_W(DATA_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(accept),
            .need_i (need[p]),
            .go_i   (rd_go_i[p]),
            .src_i  (src_i[p*DATA_W +: DATA_W]),
            .rel_o  (rel[p]),
            .opnd_o (opnd[p])
        );
    end

    cu_alu #(.DATA_W(DATA_W)) u_alu (
        .fn_i    (st_q.fn),
        .inv_a_i (st_q.inv_a),
        .zero_a_i(st_q.zero_a),
        .imm_ok_i(st_q.imm_ok),
        .imm_i   (st_q.imm),
        .opa_i   (opnd[0]),
        .opb_i   (opnd[1]),
        .res_o   (alu_res)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.phase  = PH_READ;
                    st_d.fn     = fn_e'(op_i);
                    st_d.inv_a  = inv_a_i;
                    st_d.zero_a = zero_a_i;
                    st_d.imm_ok = imm_ok_i;
                    st_d.imm    = imm_i;
                    st_d.cnt    = '0;
                end
            end
            PH_READ: begin
                if ((rel & ~rd_go_i) == '0) begin
                    st_d.phase = PH_EXEC;
                    st_d.cnt   = '0;
                end
            end
            PH_EXEC: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase  = PH_WRITE;
                    st_d.result = alu_res;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                if (wr_go_i) begin
                    st_d.phase = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.phase != PH_IDLE);
    assign rd_rel_o = rel;
    assign wr_rel_o = (st_q.phase == PH_WRITE);
    assign data_o   = (wr_rel_o && wr_go_i) ? st_q.result : '0;

    AST_BUSY_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(issue_i)); // R2
    AST_BUSY_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(wr_rel_o && wr_go_i)) |=> busy_o); // R1
    AST_BUSY_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && wr_go_i) |=> !busy_o); // R1
    AST_WR_REL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && !wr_go_i) |=> wr_rel_o); // R8
    AST_NO_READ_OUTSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_rel_o == 2'b00)); // R9

endmodule

// File: tb/cu_ctrl_bench.sv
module cu_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           issue_i = 1'b0;
    logic [1:0]     op_i = '0;
    logic           inv_a_i = 1'b0;
    logic           zero_a_i = 1'b0;
    logic           imm_ok_i = 1'b0;
    logic [W-1:0]   imm_i = '0;
    logic [1:0]     rd_mask_n_i = '0;
    logic [2*W-1:0] src_i = '0;
    logic [1:0]     rd_go_i = '0;
    logic           busy_o;
    logic [1:0]     rd_rel_o;
    logic           wr_rel_o;
    logic           wr_go_i = 1'b0;
    logic [W-1:0]   data_o;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cu_ctrl #(.DATA_W(W), .EXEC_CYCLES(2)) u_cu_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_ok_i(imm_ok_i),
        .imm_i(imm_i), .rd_mask_n_i(rd_mask_n_i), .src_i(src_i),
        .rd_go_i(rd_go_i), .busy_o(busy_o), .rd_rel_o(rd_rel_o),
        .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i), .data_o(data_o)
    );

    // op, inv, zero, imm_ok, mask, go delay p0, go delay p1, write delay, a, b, imm
    localparam logic [66:0] VEC [0:7] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 4'd0, 4'd0, 16'd5,     16'd2,     16'd0},
        {2'd1, 1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 4'd3, 4'd1, 16'd9,     16'd12,    16'd0},
        {2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 4'd2, 4'd0, 4'd0, 16'd5,     16'd2,     16'd0},
        {2'd0, 1'b0, 1'b0, 1'b1, 2'b00, 4'd1, 4'd0, 4'd2, 16'd5,     16'd700,   16'd33},
        {2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 4'd0, 4'd4, 4'd0, 16'd77,    16'd40,    16'd0},
        {2'd2, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5, 4'd5, 4'd3, 16'hF0F0,  16'h3C3C,  16'd0},
        {2'd3, 1'b1, 1'b1, 1'b1, 2'b00, 4'd0, 4'd0, 4'd0, 16'd1,     16'd2,     16'h1234},
        {2'd3, 1'b0, 1'b0, 1'b0, 2'b10, 4'd7, 4'd0, 4'd7, 16'hAAAA,  16'h5555,  16'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [1:0] op, input logic inv,
        input logic za, input logic io, input logic [1:0] mask,
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] imm);
        logic [W-1:0] ea, eb;
        ea = (za || mask[0]) ? '0 : a;
        if (inv) ea = ~ea;
        eb = io ? imm : (mask[1] ? '0 : b);
        case (op)
            2'd0: return ea + eb;
            2'd1: return ea - eb;
            2'd2: return ea & eb;
            default: return ea ^ eb;
        endcase
    endfunction

    task automatic run_op(input logic [1:0] op, input logic inv, input logic za,
        input logic io, input logic [1:0] mask, input int d0, input int d1,
        input int wd, input logic [W-1:0] a, input logic [W-1:0] b,
        input logic [W-1:0] imm, input bit stray, input bit late_issue);
        logic [W-1:0] expv;
        logic [1:0] need, done, gave;
        logic [W-1:0] val [2];
        int dly [2];
        int wcnt;
        bit wgo, finished;
        int used;
        expv = model(op, inv, za, io, mask, a, b, imm);
        need = {~mask[1] & ~io, ~mask[0] & ~za};
        val[0] = a; val[1] = b; dly[0] = d0; dly[1] = d1;
        done = '0; gave = '0; wcnt = 0; wgo = 0; finished = 0; used = 0;

        @(negedge clk);
        issue_i = 1'b1; op_i = op; inv_a_i = inv; zero_a_i = za; imm_ok_i = io;
        imm_i = imm; rd_mask_n_i = mask;
        chk(busy_o == 1'b0, "R2 busy low in issue cycle", 32'(busy_o), 0);

        @(negedge clk);
        issue_i = 1'b0; op_i = ~op; inv_a_i = ~inv; zero_a_i = ~za;
        imm_ok_i = ~io; imm_i = ~imm; rd_mask_n_i = ~mask;   // R3 scramble
        chk(busy_o == 1'b1, "R1 busy after issue", 32'(busy_o), 1);

        for (int k = 0; k < 60; k++) begin
            if (k > 0) @(negedge clk);
            rd_go_i = '0; src_i = '0; wr_go_i = 1'b0; issue_i = 1'b0;
            if (wgo) begin
                chk(busy_o == 1'b0, "R1 busy falls after write go", 32'(busy_o), 0);
                chk(wr_rel_o == 1'b0, "R8 write release cleared", 32'(wr_rel_o), 0);
                finished = 1;
                used = k + 2;
                break;
            end
            for (int i = 0; i < 2; i++) begin
                if (gave[i])
                    chk(rd_rel_o[i] == 1'b0, "R5 release low after go", 32'(rd_rel_o[i]), 0);
                else if (need[i] && !done[i])
                    chk(rd_rel_o[i] == 1'b1, "R4 release held", 32'(rd_rel_o[i]), 1);
                else
                    chk(rd_rel_o[i] == 1'b0, "R6 R9 no release on skipped or read port",
                        32'(rd_rel_o[i]), 0);
            end
            gave = '0;
            for (int i = 0; i < 2; i++) begin
                if (need[i] && !done[i] && k == dly[i]) begin
                    rd_go_i[i] = 1'b1;
                    src_i[i*W +: W] = val[i];
                    done[i] = 1'b1;
                    gave[i] = 1'b1;
                end else if (stray && !(need[i] && !done[i])) begin
                    rd_go_i[i] = 1'b1;
                    src_i[i*W +: W] = 16'hFFFF;
                end
            end
            if (late_issue && k == 1) begin
                issue_i = 1'b1; op_i = op ^ 2'd1; rd_mask_n_i = 2'b00;
            end
            if (wr_rel_o) begin
                if (wcnt == wd) begin
                    wr_go_i = 1'b1;
                    #1;
                    chk(data_o == expv, "R7 R3 result on data_o", 32'(data_o), 32'(expv));
                    wgo = 1;
                end else begin
                    chk(data_o == '0, "R8 data_o quiet before write go", 32'(data_o), 0);
                    wcnt++;
                end
            end
        end
        rd_go_i = '0; src_i = '0; wr_go_i = 1'b0; issue_i = 1'b0;
        chk(finished && used <= 50, "R10 operation within budget", 32'(used), 50);
        if (late_issue) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R9 R2 issue during busy ignored", 32'(busy_o), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R2 busy low in reset", 32'(busy_o), 0);
        chk(rd_rel_o == 2'b00, "R4 no release in reset", 32'(rd_rel_o), 0);
        chk(wr_rel_o == 1'b0, "R8 no write release in reset", 32'(wr_rel_o), 0);
        chk(data_o == '0, "R8 data_o zero in reset", 32'(data_o), 0);
        rst_n = 1'b1;

        // go pulses and write go while idle must do nothing
        @(negedge clk);
        rd_go_i = 2'b11; src_i = '1; wr_go_i = 1'b1;
        #1;
        chk(data_o == '0, "R8 write go while idle", 32'(data_o), 0);
        @(negedge clk);
        rd_go_i = '0; src_i = '0; wr_go_i = 1'b0;
        chk(busy_o == 1'b0, "R2 busy stays low without issue", 32'(busy_o), 0);
        chk(rd_rel_o == 2'b00, "R5 go while idle ignored", 32'(rd_rel_o), 0);

        // vector table
        for (int v = 0; v < 8; v++) begin
            run_op(VEC[v][66:65], VEC[v][64], VEC[v][63], VEC[v][62], VEC[v][61:60],
                   int'(VEC[v][59:56]), int'(VEC[v][55:52]), int'(VEC[v][51:48]),
                   VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 1'b0, 1'b0);
        end

        // directed: stray go on skipped ports (R5, R6)
        run_op(2'd0, 1'b0, 1'b0, 1'b0, 2'b11, 0, 0, 0, 16'd3, 16'd4, 16'd0, 1'b1, 1'b0);
        run_op(2'd0, 1'b0, 1'b1, 1'b1, 2'b00, 0, 0, 1, 16'd3, 16'd4, 16'd9, 1'b1, 1'b0);
        // directed: stray go on port 0 after it has been read (R5)
        run_op(2'd1, 1'b0, 1'b0, 1'b0, 2'b00, 0, 6, 0, 16'd100, 16'd1, 16'd0, 1'b1, 1'b0);
        // directed: issue while busy (R9)
        run_op(2'd3, 1'b0, 1'b0, 1'b0, 2'b00, 3, 2, 4, 16'h0F0F, 16'h00FF, 16'd0, 1'b0, 1'b1);
        // directed: longest delays on every handshake (R10)
        run_op(2'd0, 1'b1, 1'b0, 1'b0, 2'b00, 7, 7, 7, 16'hFFFF, 16'd1, 16'd0, 1'b0, 1'b0);

        // no spontaneous busy afterwards (R2)
        repeat (5) @(negedge clk);
        chk(busy_o == 1'b0, "R2 busy stays low when idle", 32'(busy_o), 0);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule